// File: doc/BRIEF.md
# Clock Synthesizer Register Port

This block holds the byte registers that program a graphics controller's clock synthesizer. The host reaches them indirectly through a narrow host bus. It first writes an address byte, which carries a six-bit register index and a write-enable flag. It then reads or writes a data port that maps onto the register the latched index names. A third port holds the pixel-clock select.

The registers cover the following settings:
- a reference divider
- a memory-clock feedback divider and its extended control
- four pixel-clock feedback dividers
- a packed pixel post-divider byte
- general control and pixel-clock control bytes

The analog loop is not modelled. The block decodes the divider settings of the memory clock and of the currently selected pixel clock, and drives them as outputs for the loop logic.

A host programs a register in three writes: the address byte with the flag set, the data byte, and the same address with the flag cleared. To read a register, it writes the address with the flag clear and then reads the data port. The only way to change a register is a data write while the flag is set, so a stray data-port access cannot disturb a running clock.

Top module: `clksyn_regport`

## Requirements
- R1: `bus_port` selects one of four ports: 0 = address, 1 = data, 2 = pixel-clock select, 3 = unused. A write to port 0 stores the full byte, and a read of port 0 returns it. The latched index is bits [7:2] and the write-enable flag is bit 1.
- R2: With the write-enable flag clear, a read of port 1 returns the register named by the latched index. The index map is:
  - 1: general control
  - 2: reference divider
  - 3: pixel-clock control
  - 4: memory feedback divider
  - 5: pixel post-divider byte
  - 6 to 9: pixel feedback dividers 0 to 3
  - 10: extended control
- R3: A port-1 write while the write-enable flag is clear leaves every register unchanged.
- R4: A port-1 write while the write-enable flag is set loads the addressed register from the next clock edge. The three-step sequence (address with the flag set, data, address with the flag cleared) leaves the new value readable.
- R5: A read of any index outside the map returns 0x00, and a write to such an index changes no register. Port 3 reads 0x00 and ignores writes.
- R6: The post-divider byte holds a 2-bit code for pixel clock n in bits [2n+1:2n]. The field of the selected clock drives `pix_post_div` as 1, 2, 4 or 8 for codes 0, 1, 2 and 3.
- R7: Port 2 keeps its low 2 bits as the pixel-clock select, and a read of port 2 returns them zero-extended. The select chooses which feedback divider drives `pix_fb_div` and which post-divider field drives `pix_post_div`.
- R8: Bits [2:0] of the extended control register decode into `mem_post_div` as follows:
  - codes 0 to 4 give 1, 2, 4, 8 and 3
  - codes 5 to 7 give 0, meaning unsupported
- R9: Bit 3 of the extended control register sets `mem_fb_mult` to 4. When the bit is clear, `mem_fb_mult` is 2.
- R10: After reset the following hold:
  - the address byte, the select and every register are zero, except the four pixel feedback dividers, which hold 128
  - `mem_fb_mult` is 2
  - `mem_post_div` and `pix_post_div` are 1

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_port | input | 2 | Port select: 0 address, 1 data, 2 clock select, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected port (combinational) |
| ref_div | output | 8 | Reference divider |
| mem_fb_div | output | 8 | Memory-clock feedback divider |
| mem_fb_mult | output | 3 | Memory feedback multiplier, 2 or 4 |
| mem_post_div | output | 4 | Decoded memory post divider, 0 if unsupported |
| pix_sel | output | 2 | Active pixel-clock index |
| pix_fb_div | output | 8 | Feedback divider of the active pixel clock |
| pix_post_div | output | 4 | Decoded post divider of the active pixel clock |
| gen_ctl | output | 8 | General control byte |
| pix_ctl | output | 8 | Pixel-clock control byte |

## Verification
The bench builds the block with its defaults: four pixel clocks and a feedback reset value of 128. With four clocks, all select values and every bit pair of the post-divider byte can be reached, including the top field for clock 3. The default index map puts index 20 outside the map, which lets the bench check that a write there is ignored. Every one of the eight extended-control codes can be driven, so each entry of the memory post-divider decode is checked, including the three unsupported codes.

// File: rtl/clksyn_pkg.sv
// Shared constants and decode helpers for the clock synthesizer register port.
// Assumes an 8-bit host bus and a 6-bit register index.
package clksyn_pkg;
    localparam int IDX_W        = 6;
    localparam int IDX_GEN      = 1;
    localparam int IDX_REF      = 2;
    localparam int IDX_VCTL     = 3;
    localparam int IDX_MEMFB    = 4;
    localparam int IDX_POST     = 5;
    localparam int IDX_FB_BASE  = 6;
    localparam int IDX_EXT      = 10;
    localparam int EXT_MULT_BIT = 3;

    typedef enum logic [1:0] {
        PORT_ADDR = 2'd0,
        PORT_DATA = 2'd1,
        PORT_CSEL = 2'd2,
        PORT_NONE = 2'd3
    } port_e;

    // Memory post-divider code to divide ratio; 0 marks an unsupported code.
    function automatic logic [3:0] mem_post_ratio(input logic [2:0] code);
        case (code)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            3'd3:    return 4'd8;
            3'd4:    return 4'd3;
            default: return 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/clksyn_regfile.sv
// Byte register file behind the data port.
// A data write takes effect only while the latched write-enable flag is set.
// Indices outside the map read as zero and drop writes.
module clksyn_regfile
    import clksyn_pkg::*;
#(
    parameter int          NUM_PIX = 4,
    parameter logic [7:0]  FB_RST  = 8'd128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_stb,
    input  logic                    wr_en_flag,
    input  logic [IDX_W-1:0]        idx,
    input  logic [7:0]              wdata,
    output logic [7:0]              rdata,
    output logic [7:0]              ref_q,
    output logic [7:0]              memfb_q,
    output logic [7:0]              post_q,
    output logic [7:0]              ext_q,
    output logic [7:0]              gen_q,
    output logic [7:0]              vctl_q,
    output logic [NUM_PIX-1:0][7:0] fb_q
);
    logic commit;
    assign commit = wr_stb & wr_en_flag;

    // Load the scalar control and divider registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= '0;
            memfb_q <= '0;
            post_q  <= '0;
            ext_q   <= '0;
            gen_q   <= '0;
            vctl_q  <= '0;
        end else if (commit) begin
            case (idx)
                IDX_W'(IDX_GEN):   gen_q   <= wdata;
                IDX_W'(IDX_REF):   ref_q   <= wdata;
                IDX_W'(IDX_VCTL):  vctl_q  <= wdata;
                IDX_W'(IDX_MEMFB): memfb_q <= wdata;
                IDX_W'(IDX_POST):  post_q  <= wdata;
                IDX_W'(IDX_EXT):   ext_q   <= wdata;
                default: ;
            endcase
        end
    end

    // One feedback divider per pixel clock at consecutive indices.
    for (genvar g = 0; g < NUM_PIX; g++) begin : g_fb
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX_FB_BASE + g);
        // Load this pixel clock's feedback divider.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fb_q[g] <= FB_RST;
            else if (commit && idx == MY_IDX)
                fb_q[g] <= wdata;
        end
    end

    // Select the register named by the index for the data port read.
    always_comb begin
        rdata = '0;
        case (idx)
            IDX_W'(IDX_GEN):   rdata = gen_q;
            IDX_W'(IDX_REF):   rdata = ref_q;
            IDX_W'(IDX_VCTL):  rdata = vctl_q;
            IDX_W'(IDX_MEMFB): rdata = memfb_q;
            IDX_W'(IDX_POST):  rdata = post_q;
            IDX_W'(IDX_EXT):   rdata = ext_q;
            default: ;
        endcase
        for (int k = 0; k < NUM_PIX; k++)
            if (idx == IDX_W'(IDX_FB_BASE + k)) rdata = fb_q[k];
    end

    logic [6*8+NUM_PIX*8-1:0] snapshot;
    assign snapshot = {ref_q, memfb_q, post_q, ext_q, gen_q, vctl_q, fb_q};

    // R3: a data write with the flag clear changes no register.
    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_en_flag) |=> $stable(snapshot));

    // R4: an enabled write to the first feedback index loads that divider.
    p_fb_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_en_flag && idx == IDX_W'(IDX_FB_BASE)) |=> fb_q[0] == $past(wdata));
endmodule

// File: rtl/clksyn_decode.sv
// Turns stored divider codes into ratios for the loop logic.
// Assumes 2-bit pixel post-divider fields packed in one byte.
module clksyn_decode
    import clksyn_pkg::*;
#(
    parameter int NUM_PIX = 4,
    localparam int SEL_W  = $clog2(NUM_PIX)
) (
    input  logic [SEL_W-1:0]        sel,
    input  logic [7:0]              post_q,
    input  logic [7:0]              ext_q,
    input  logic [NUM_PIX-1:0][7:0] fb_q,
    output logic [7:0]              pix_fb_div,
    output logic [3:0]              pix_post_div,
    output logic [3:0]              mem_post_div,
    output logic [2:0]              mem_fb_mult
);
    logic [1:0] field;

    // Pick the active pixel clock's divider settings.
    always_comb begin
        pix_fb_div   = fb_q[sel];
        field        = post_q[2*sel +: 2];
        pix_post_div = 4'd1 << field;
    end

    // Decode the memory clock's post divider and feedback multiplier.
    always_comb begin
        mem_post_div = mem_post_ratio(ext_q[2:0]);
        mem_fb_mult  = ext_q[EXT_MULT_BIT] ? 3'd4 : 3'd2;
    end
endmodule

// File: rtl/clksyn_regport.sv
// Indirect host access port for the clock synthesizer registers.
// Holds the address byte and the pixel-clock select, and routes reads.
// Assumes a single-cycle write strobe and a combinational read.
module clksyn_regport
    import clksyn_pkg::*;
#(
    parameter int         NUM_PIX = 4,
    parameter logic [7:0] FB_RST  = 8'd128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [1:0] bus_port,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic [7:0] ref_div,
    output logic [7:0] mem_fb_div,
    output logic [2:0] mem_fb_mult,
    output logic [3:0] mem_post_div,
    output logic [1:0] pix_sel,
    output logic [7:0] pix_fb_div,
    output logic [3:0] pix_post_div,
    output logic [7:0] gen_ctl,
    output logic [7:0] pix_ctl
);
    localparam int SEL_W = $clog2(NUM_PIX);

    logic [7:0]              addr_q;
    logic [SEL_W-1:0]        sel_q;
    logic [7:0]              reg_rdata;
    logic [7:0]              post_q, ext_q;
    logic [NUM_PIX-1:0][7:0] fb_q;
    port_e                   port;

    assign port = port_e'(bus_port);

    // Latch the address byte and the pixel-clock select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            sel_q  <= '0;
        end else if (bus_wr) begin
            if (port == PORT_ADDR) addr_q <= bus_wdata;
            if (port == PORT_CSEL) sel_q  <= bus_wdata[SEL_W-1:0];
        end
    end

    clksyn_regfile #(.NUM_PIX(NUM_PIX), .FB_RST(FB_RST)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (bus_wr && port == PORT_DATA),
        .wr_en_flag (addr_q[1]),
        .idx        (addr_q[7:2]),
        .wdata      (bus_wdata),
        .rdata      (reg_rdata),
        .ref_q      (ref_div),
        .memfb_q    (mem_fb_div),
        .post_q     (post_q),
        .ext_q      (ext_q),
        .gen_q      (gen_ctl),
        .vctl_q     (pix_ctl),
        .fb_q       (fb_q)
    );

    clksyn_decode #(.NUM_PIX(NUM_PIX)) i_dec (
        .sel          (sel_q),
        .post_q       (post_q),
        .ext_q        (ext_q),
        .fb_q         (fb_q),
        .pix_fb_div   (pix_fb_div),
        .pix_post_div (pix_post_div),
        .mem_post_div (mem_post_div),
        .mem_fb_mult  (mem_fb_mult)
    );

    assign pix_sel = 2'(sel_q);

    // Route the selected port to the read bus.
    always_comb begin
        case (port)
            PORT_ADDR: bus_rdata = addr_q;
            PORT_DATA: bus_rdata = reg_rdata;
            PORT_CSEL: bus_rdata = 8'(sel_q);
            default:   bus_rdata = '0;
        endcase
    end

    // R1: an address-port write is held as the address byte.
    p_addr_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_port == 2'd0) |=> addr_q == $past(bus_wdata));

    // R7: a select-port write moves the active pixel clock.
    p_sel_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_port == 2'd2) |=> pix_sel == $past(bus_wdata[1:0]));
endmodule

// File: tb/test_clksyn_regport.sv
`timescale 1ns/1ps
module test_clksyn_regport;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_port = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata, ref_div, mem_fb_div, gen_ctl, pix_ctl, pix_fb_div;
    logic [2:0] mem_fb_mult;
    logic [3:0] mem_post_div, pix_post_div;
    logic [1:0] pix_sel;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    clksyn_regport i_clksyn_regport (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_port(bus_port),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_div(ref_div),
        .mem_fb_div(mem_fb_div), .mem_fb_mult(mem_fb_mult), .mem_post_div(mem_post_div),
        .pix_sel(pix_sel), .pix_fb_div(pix_fb_div), .pix_post_div(pix_post_div),
        .gen_ctl(gen_ctl), .pix_ctl(pix_ctl)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] abyte(input int idx, input bit we);
        return 8'((idx << 2) | (int'(we) << 1));
    endfunction

    task automatic bus_write(input int port, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_port = 2'(port); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int port, output logic [7:0] d);
        @(negedge clk);
        bus_port = 2'(port);
        #1 d = bus_rdata;
    endtask

    task automatic reg_write(input int idx, input logic [7:0] d);
        bus_write(0, abyte(idx, 1'b1));
        bus_write(1, d);
        bus_write(0, abyte(idx, 1'b0));
    endtask

    task automatic reg_read(input int idx, output logic [7:0] d);
        bus_write(0, abyte(idx, 1'b0));
        bus_read(1, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(0, d);         check("R10 addr byte", d, 0);
        check("R10 pix_fb_div", pix_fb_div, 128);
        check("R10 pix_post_div", pix_post_div, 1);
        check("R10 mem_post_div", mem_post_div, 1);
        check("R10 mem_fb_mult", mem_fb_mult, 2);
        check("R10 ref_div", ref_div, 0);
        reg_read(9, d);         check("R10 fb3 via R2 read", d, 128);
        reg_read(1, d);         check("R10 gen via R2 read", d, 0);
    endtask

    task automatic t_addr_port();
        logic [7:0] d;
        bus_write(0, 8'hA6);
        bus_read(0, d);         check("R1 address readback", d, 8'hA6);
    endtask

    task automatic t_write_read();
        logic [7:0] d;
        reg_write(2, 8'h5A);    check("R4 ref_div output", ref_div, 8'h5A);
        reg_read(2, d);         check("R4 ref readback", d, 8'h5A);
        reg_write(4, 8'hC3);    check("R2 mem_fb_div", mem_fb_div, 8'hC3);
        reg_write(3, 8'h11);    check("R2 pix_ctl", pix_ctl, 8'h11);
    endtask

    task automatic t_locked();
        logic [7:0] d;
        bus_write(0, abyte(2, 1'b0));
        bus_write(1, 8'hFF);
        bus_read(1, d);         check("R3 locked write ignored", d, 8'h5A);
        check("R3 ref_div unchanged", ref_div, 8'h5A);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        reg_write(20, 8'h77);
        reg_read(20, d);        check("R5 unmapped read", d, 0);
        reg_read(2, d);         check("R5 ref untouched", d, 8'h5A);
        check("R5 gen untouched", gen_ctl, 0);
        bus_write(3, 8'h99);
        bus_read(3, d);         check("R5 port3 reads zero", d, 0);
    endtask

    task automatic t_pixel();
        logic [7:0] d;
        reg_write(5, 8'hE4);
        for (int n = 0; n < 4; n++) reg_write(6 + n, 8'(130 + n));
        for (int n = 0; n < 4; n++) begin
            bus_write(2, 8'(n) | 8'hFC);
            bus_read(2, d);     check("R7 select readback", d, n);
            check("R7 pix_sel", pix_sel, n);
            check("R7 pix_fb_div", pix_fb_div, 130 + n);
            check("R6 pix_post_div", pix_post_div, 1 << n);
        end
        reg_write(5, 8'h1B);
        bus_write(2, 8'd0);     check("R6 field0 code3", pix_post_div, 8);
    endtask

    task automatic t_ext();
        int exp;
        for (int c = 0; c < 8; c++) begin
            reg_write(10, 8'(c));
            case (c)
                0: exp = 1; 1: exp = 2; 2: exp = 4; 3: exp = 8; 4: exp = 3;
                default: exp = 0;
            endcase
            check("R8 mem_post_div", mem_post_div, exp);
            check("R9 mult clear", mem_fb_mult, 2);
        end
        reg_write(10, 8'h0A);
        check("R9 mult four", mem_fb_mult, 4);
        check("R8 code with flag", mem_post_div, 4);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_addr_port();
        t_write_read();
        t_locked();
        t_unmapped();
        t_pixel();
        t_ext();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule